// File: doc/BRIEF.md
# Split Prefix/Ripple Adder for an Operand with a Fixed All-Ones Top Field

This block is a purely combinational two-operand binary adder of width `W`. The second operand has a special shape: its upper `K` bits are always logic 1 and only its lower `L = W - K` bits are supplied. Such an operand shows up in the last stage of residue-to-binary converters, where a subtractor is rewritten as an adder and a run of constant ones appears at the top of one input.

The adder is cut into two sections. The lower `L` bits, where both inputs are free, go through a full parallel-prefix carry network. The parameter `NET` picks either a sparse up/down-sweep tree (Brent-Kung style) or a dense log-depth tree (Kogge-Stone style). The upper `K` bits go through a short ripple chain. There, the constant 1 reduces every full adder to one XNOR for the sum and one OR for the carry. The carry out of the prefix section feeds the first ripple cell, and the last ripple carry is the block's carry-out.

The block has no clock, no state and no handshake. Results follow the inputs after the combinational delay. A caller that needs pipelining places registers around it.

Top module: `hybrid_const_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals the (W+1)-bit value `a + B`. Here `B` has bits `W-1..L` all set to 1 and bits `L-1..0` equal to `b_lo`.
- R2: `sum[L-1:0]` equals the low `L` bits of `a[L-1:0] + b_lo` and does not depend on `a[W-1:L]`.
- R3: The carry out of the lower `L` bits enters upper bit `L`. Each upper bit `i` gives sum `~(a[i] ^ c[i])` and carry `a[i] | c[i]`. So lower `a` all ones with `b_lo = 1` and upper `a` zero gives `sum = 0`, `cout = 1`. Lower `a` all ones with `b_lo = 0` gives upper sum all ones and `cout = 0`.
- R4: Whenever `a[L-1:0] + b_lo >= 2**L`, `sum[W-1:L]` equals `a[W-1:L]` and `cout` is 1.
- R5: Whenever `a[L-1:0] + b_lo < 2**L`, `cout` is 1 exactly when `a[W-1:L]` is nonzero, and `sum[W-1:L]` equals `a[W-1:L] - 1` modulo `2**K`.
- R6: `NET = NET_BK` and `NET = NET_KS` give bit-identical `sum` and `cout` for the same inputs and widths.
- R7: R1 holds for lower widths that are not a power of two, for a lower width of 1 and for `K = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, all bits free |
| b_lo | input | W-K | Free low field of the second operand; its top K bits are implied ones |
| sum | output | W | Low W bits of the total |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
Two things can act on the same input vector: the prefix section generates a carry, and the ripple section turns that carry into the upper result. When the lower field overflows, the ripple section must copy `a`'s upper bits through unchanged and force the carry-out. When it does not overflow, the upper result becomes `a`'s upper field minus one. Directed corners reach the boundary from both sides: a lower `a` of all ones with `b_lo` of 1 or 0. Random and exhaustive vectors then cover both cases over every upper pattern. Each result is judged against an independent wide addition and against the rule for whichever case applies.

// File: rtl/hca_pkg.sv
package hca_pkg;
  typedef enum logic [0:0] {
    NET_BK = 1'b0,
    NET_KS = 1'b1
  } net_e;

  function automatic int lvls(input int width);
    return (width < 2) ? 1 : $clog2(width);
  endfunction
endpackage

// File: rtl/hca_prefix.sv
module hca_prefix
  import hca_pkg::*;
#(
  parameter int   WD  = 10,
  parameter net_e NET = NET_BK
) (
  input  logic [WD-1:0] a,
  input  logic [WD-1:0] b,
  output logic [WD-1:0] s,
  output logic          co
);
  localparam int LV  = lvls(WD);
  localparam int N   = 1 << LV;
  localparam int LEV = (NET == NET_KS) ? LV : 2 * LV - 1;

  logic [LEV:0][N-1:0] gg;
  logic [LEV:0][N-1:0] pp;
  logic [N-1:0]        cin_v;

  // bitwise generate / propagate, padded with zeros up to N
  for (genvar i = 0; i < N; i++) begin : g_pre
    if (i < WD) begin : g_real
      assign gg[0][i] = a[i] & b[i];
      assign pp[0][i] = a[i] ^ b[i];
    end else begin : g_pad
      assign gg[0][i] = 1'b0;
      assign pp[0][i] = 1'b0;
    end
  end

  for (genvar t = 0; t < LEV; t++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (NET == NET_KS) begin : g_ks
        localparam int D = 1 << t;
        if (i >= D) begin : g_cell
          assign gg[t+1][i] = gg[t][i] | (pp[t][i] & gg[t][i-D]);
          assign pp[t+1][i] = pp[t][i] & pp[t][i-D];
        end else begin : g_buf
          assign gg[t+1][i] = gg[t][i];
          assign pp[t+1][i] = pp[t][i];
        end
      end else begin : g_bk
        localparam bit UP = (t < LV);
        localparam int S  = UP ? t : (2 * LV - 2 - t);
        localparam int SP = 2 << S;
        localparam int D  = 1 << S;
        localparam bit HIT = UP ? (((i + 1) % SP) == 0)
                                : ((((i + 1) % SP) == D) && ((i + 1) > SP));
        if (HIT) begin : g_cell
          assign gg[t+1][i] = gg[t][i] | (pp[t][i] & gg[t][i-D]);
          assign pp[t+1][i] = pp[t][i] & pp[t][i-D];
        end else begin : g_buf
          assign gg[t+1][i] = gg[t][i];
          assign pp[t+1][i] = pp[t][i];
        end
      end
    end
  end

  // carry into bit i is the group generate of bits i-1..0 (carry-in zero)
  assign cin_v = {gg[LEV][N-2:0], 1'b0};
  assign s     = pp[0][WD-1:0] ^ cin_v[WD-1:0];
  assign co    = gg[LEV][WD-1];

  // R2: section result matches a plain wide sum
  always_comb begin
    a_r2_prefix_sum: assert ({co, s} == ({1'b0, a} + {1'b0, b}))
      else $error("prefix section sum mismatch");
  end
endmodule

// File: rtl/hca_ones_ripple.sv
module hca_ones_ripple #(
  parameter int WD = 6
) (
  input  logic [WD-1:0] a,
  input  logic          ci,
  output logic [WD-1:0] s,
  output logic          co
);
  logic [WD:0] c;

  assign c[0] = ci;
  for (genvar j = 0; j < WD; j++) begin : g_cell
    assign s[j]   = ~(a[j] ^ c[j]);
    assign c[j+1] = a[j] | c[j];
  end
  assign co = c[WD];

  always_comb begin
    if (ci) begin
      a_r4_pass_through: assert (s == a && co)
        else $error("carried upper field not passed through");
    end else begin
      a_r5_decrement: assert (co == (|a) && s == a - 1'b1)
        else $error("uncarried upper field not decremented");
    end
  end
endmodule

// File: rtl/hybrid_const_adder.sv
module hybrid_const_adder
  import hca_pkg::*;
#(
  parameter int   W   = 16,
  parameter int   K   = 6,
  parameter net_e NET = NET_BK
) (
  input  logic [W-1:0]   a,
  input  logic [W-K-1:0] b_lo,
  output logic [W-1:0]   sum,
  output logic           cout
);
  localparam int L = W - K;

  logic c_mid;

  hca_prefix #(.WD(L), .NET(NET)) u_pfx (
    .a (a[L-1:0]),
    .b (b_lo),
    .s (sum[L-1:0]),
    .co(c_mid)
  );

  hca_ones_ripple #(.WD(K)) u_rip (
    .a (a[W-1:L]),
    .ci(c_mid),
    .s (sum[W-1:L]),
    .co(cout)
  );

  // R1: whole result equals a plus the implied operand
  always_comb begin
    a_r1_total: assert ({cout, sum} == ({1'b0, a} + {1'b0, {K{1'b1}}, b_lo}))
      else $error("total sum mismatch");
  end
endmodule

// File: tb/hybrid_const_adder_bench.sv
module hybrid_const_adder_bench;
  import hca_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // default 16/6 pair, both networks
  logic [15:0] d_a;  logic [9:0] d_b;
  logic [15:0] d_s, k_s; logic d_c, k_c;
  // small exhaustive shapes
  logic [5:0] s1_a, s1_s; logic [3:0] s1_b; logic s1_c;
  logic [5:0] s2_a, s2_s; logic [2:0] s2_b; logic s2_c;
  logic [4:0] s3_a, s3_s; logic [0:0] s3_b; logic s3_c;
  logic [4:0] s4_a, s4_s; logic [3:0] s4_b; logic s4_c;
  // wide shape, odd lower width
  logic [39:0] w_a, w_s; logic [22:0] w_b; logic w_c;

  hybrid_const_adder u_hybrid_const_adder (.a(d_a), .b_lo(d_b), .sum(d_s), .cout(d_c));
  hybrid_const_adder #(.W(16), .K(6), .NET(NET_KS)) u_ks16 (.a(d_a), .b_lo(d_b), .sum(k_s), .cout(k_c));
  hybrid_const_adder #(.W(6), .K(2), .NET(NET_KS)) u_s1 (.a(s1_a), .b_lo(s1_b), .sum(s1_s), .cout(s1_c));
  hybrid_const_adder #(.W(6), .K(3), .NET(NET_BK)) u_s2 (.a(s2_a), .b_lo(s2_b), .sum(s2_s), .cout(s2_c));
  hybrid_const_adder #(.W(5), .K(4), .NET(NET_BK)) u_s3 (.a(s3_a), .b_lo(s3_b), .sum(s3_s), .cout(s3_c));
  hybrid_const_adder #(.W(5), .K(1), .NET(NET_KS)) u_s4 (.a(s4_a), .b_lo(s4_b), .sum(s4_s), .cout(s4_c));
  hybrid_const_adder #(.W(40), .K(17), .NET(NET_KS)) u_w (.a(w_a), .b_lo(w_b), .sum(w_s), .cout(w_c));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_sum(input logic [63:0] av, input logic [63:0] bv,
                                          input int w, input int k);
    logic [63:0] ones = ((64'd1 << k) - 64'd1) << (w - k);
    return av + (ones | bv);
  endfunction

  task automatic drive16(input logic [15:0] av, input logic [9:0] bv);
    @(negedge clk);
    d_a = av; d_b = bv;
    #1;
  endtask

  // baseline right after reset: zero inputs
  task automatic t_zero();
    drive16(16'h0, 10'h0);
    chk("R1 zero", {47'd0, d_c, d_s}, 64'h0FC00);
  endtask

  // R3: boundary of the hand-off from both sides
  task automatic t_handoff();
    drive16(16'h03FF, 10'h001);
    chk("R3 carry in", {47'd0, d_c, d_s}, 64'h10000);
    drive16(16'h03FF, 10'h000);
    chk("R3 no carry", {47'd0, d_c, d_s}, 64'h0FFFF);
    drive16(16'hFFFF, 10'h3FF);
    chk("R3 max", {47'd0, d_c, d_s}, ref_sum(64'hFFFF, 64'h3FF, 16, 6));
  endtask

  // R1/R2/R4/R5/R6 on random vectors
  task automatic t_random16();
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] av;
      logic [9:0]  bv;
      logic [10:0] lo;
      av = 16'($urandom);
      bv = 10'($urandom);
      if (n % 4 == 0) bv = ~av[9:0];
      if (n % 4 == 1) bv = 10'(~av[9:0] + 10'd1);
      drive16(av, bv);
      lo = {1'b0, av[9:0]} + {1'b0, bv};
      chk("R1 rand", {47'd0, d_c, d_s}, ref_sum({48'd0, av}, {54'd0, bv}, 16, 6));
      chk("R2 low", {54'd0, d_s[9:0]}, {54'd0, lo[9:0]});
      if (lo[10]) begin
        chk("R4 pass", {57'd0, d_c, d_s[15:10]}, {57'd0, 1'b1, av[15:10]});
      end else begin
        chk("R5 dec", {57'd0, d_c, d_s[15:10]}, {57'd0, |av[15:10], 6'(av[15:10] - 6'd1)});
      end
      chk("R6 nets", {47'd0, k_c, k_s}, {47'd0, d_c, d_s});
    end
  endtask

  // R2: upper a has no effect on lower sum
  task automatic t_upper_isolated();
    logic [9:0] ref_lo;
    drive16(16'h0155, 10'h2AA);
    ref_lo = d_s[9:0];
    for (int u = 0; u < 64; u++) begin
      drive16({6'(u), 10'h155}, 10'h2AA);
      chk("R2 isolate", {54'd0, d_s[9:0]}, {54'd0, ref_lo});
    end
  endtask

  task automatic t_exh_s1();
    for (int av = 0; av < 64; av++)
      for (int bv = 0; bv < 16; bv++) begin
        @(negedge clk); s1_a = 6'(av); s1_b = 4'(bv); #1;
        chk("R1 exh 6/2", {57'd0, s1_c, s1_s}, ref_sum(64'(av), 64'(bv), 6, 2));
      end
  endtask

  task automatic t_exh_s2();
    for (int av = 0; av < 64; av++)
      for (int bv = 0; bv < 8; bv++) begin
        @(negedge clk); s2_a = 6'(av); s2_b = 3'(bv); #1;
        chk("R7 exh 6/3", {57'd0, s2_c, s2_s}, ref_sum(64'(av), 64'(bv), 6, 3));
      end
  endtask

  task automatic t_exh_s3();
    for (int av = 0; av < 32; av++)
      for (int bv = 0; bv < 2; bv++) begin
        @(negedge clk); s3_a = 5'(av); s3_b = 1'(bv); #1;
        chk("R7 exh L1", {58'd0, s3_c, s3_s}, ref_sum(64'(av), 64'(bv), 5, 4));
      end
  endtask

  task automatic t_exh_s4();
    for (int av = 0; av < 32; av++)
      for (int bv = 0; bv < 16; bv++) begin
        @(negedge clk); s4_a = 5'(av); s4_b = 4'(bv); #1;
        chk("R7 exh K1", {58'd0, s4_c, s4_s}, ref_sum(64'(av), 64'(bv), 5, 1));
      end
  endtask

  task automatic t_wide();
    for (int n = 0; n < 1500; n++) begin
      logic [39:0] av;
      logic [22:0] bv;
      av = {8'($urandom), 32'($urandom)};
      bv = 23'($urandom);
      if (n == 0) begin av = {17'd0, 23'h7FFFFF}; bv = 23'd1; end
      if (n == 1) begin av = 40'hFF_FFFF_FFFF; bv = 23'h7FFFFF; end
      @(negedge clk); w_a = av; w_b = bv; #1;
      chk("R7 wide", {23'd0, w_c, w_s}, ref_sum({24'd0, av}, {41'd0, bv}, 40, 17));
    end
  endtask

  initial begin
    d_a = '0; d_b = '0; s1_a = '0; s1_b = '0; s2_a = '0; s2_b = '0;
    s3_a = '0; s3_b = '0; s4_a = '0; s4_b = '0; w_a = '0; w_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero();
    t_handoff();
    t_upper_isolated();
    t_random16();
    t_exh_s1();
    t_exh_s2();
    t_exh_s3();
    t_exh_s4();
    t_wide();
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule